// File: doc/BRIEF.md
# Receive FIFO with Interrupt Status

This block sits behind an infrared pulse sampler. It stores the run-length bytes that the sampler produces in a small first-in first-out buffer, and it lets a processor drain them through single-cycle register reads. A status word reports the live number of stored bytes together with three sticky event flags: an entry was lost because the buffer was full, the sampler signalled the end of a burst, and the buffer holds at least a programmed number of bytes. Each flag has its own enable. The enabled flags are combined into one registered, level-sensitive interrupt line.

The sampler side is a valid/ready stream. `smp_ready` is high at all times after reset, so there is no back-pressure: the sampler never stalls. A byte offered while the buffer is full and not being drained in the same cycle is dropped and recorded in the overflow flag. The processor side is a plain strobe interface. A read strobe returns its word on `reg_rdata` in the cycle after the strobe. A write strobe takes effect at the clock edge where it is sampled. Read and write strobes are not issued in the same cycle.

Top module: `cir_rx_buffer`

## Requirements
- R1: The buffer holds 16 bytes and returns them in arrival order. Each read of offset 0x20 removes one byte and returns it in bits 7:0 of `reg_rdata` one cycle after the strobe, with the other bits zero.
- R2: A read of offset 0x30 returns the number of stored bytes in bits 13:8. It returns the overflow flag in bit 0, the packet-end flag in bit 1 and the data-available flag in bit 4. All other bits are zero. The values are those held before the read edge.
- R3: A byte offered while 16 bytes are stored, with no removal in the same cycle, is discarded. The stored bytes and their order are unchanged, and the overflow flag is set. A byte offered at full in the same cycle as a removal is accepted.
- R4: A read of offset 0x20 while the buffer is empty returns 0 and leaves the count unchanged.
- R5: A one-cycle pulse on `smp_pkt_end` sets the packet-end flag.
- R6: The data-available flag is set while the count is at least (level field + 1). After it is cleared, it sets again one cycle later if that condition still holds.
- R7: Writing offset 0x30 clears each flag whose bit in `reg_wdata[7:0]` is 1. Bits written as 0 leave their flag as it is. An overflow or packet-end event in the same cycle as its clear leaves the flag set.
- R8: Offset 0x2C holds the overflow enable (bit 0), the packet-end enable (bit 1), the data-available enable (bit 4) and the 4-bit level field (bits 11:8). Its other bits read as zero.
- R9: `irq` is registered. In each cycle it equals the OR, taken over the three flags, of each flag ANDed with its enable, using the values of the previous cycle.
- R10: Offsets 0x00, 0x10 and 0x34 are 32-bit read/write holding registers. Any other offset reads as 0, and a write to it has no effect.
- R11: After reset the count, flags, enables, level, holding registers and `irq` are all zero, and `smp_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sampler byte valid |
| smp_ready | output | 1 | Always high; no back-pressure |
| smp_data | input | 8 | Sampler run-length byte |
| smp_pkt_end | input | 1 | One-cycle end-of-burst pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Level interrupt from the enabled flags |

## Verification
The bench fills the buffer past its capacity and then drains it, checking that the extra bytes never appear. A design that overwrote the oldest byte or advanced its write pointer would show the wrong order or a wrong count. It offers a byte at full in the same cycle as a read; a design that dropped that byte would come up one entry short. It clears the data-available flag while the count stays above the trigger, expecting the flag to return one cycle later, and it clears a flag in the same cycle as a new event, which catches clear-over-set priority errors. Reads of an empty buffer must return zero without pushing the count negative. Together with the randomized traffic, the per-cycle check of `irq` exposes an interrupt that is combinational or that ignores its enables.

// File: rtl/cirb_pkg.sv
package cirb_pkg;
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_RXCFG = 8'h10;
  localparam logic [7:0] OFS_DATA  = 8'h20;
  localparam logic [7:0] OFS_IEN   = 8'h2C;
  localparam logic [7:0] OFS_STAT  = 8'h30;
  localparam logic [7:0] OFS_SMPL  = 8'h34;

  localparam int FLG_OVF   = 0;
  localparam int FLG_PEND  = 1;
  localparam int FLG_AVAIL = 4;
  localparam int LVL_LSB   = 8;
  localparam int CNT_LSB   = 8;
  localparam int CNT_W     = 6;
  localparam int NHOLD     = 3;

  typedef struct packed {
    logic avail;
    logic pend;
    logic ovf;
  } flags_t;

  function automatic logic [7:0] hold_offset(input int idx);
    case (idx)
      0:       return OFS_CTRL;
      1:       return OFS_RXCFG;
      default: return OFS_SMPL;
    endcase
  endfunction
endpackage

// File: rtl/cirb_fifo.sv
module cirb_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [DW-1:0] push_data,
  input  logic          pop_req,
  output logic [DW-1:0] head_data,
  output logic [CW-1:0] count,
  output logic          pop_ok,
  output logic          ovf_evt
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          full_eff, push_ok;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    pop_ok   = pop_req && (count != '0);
    full_eff = (count == CW'(DEPTH)) && !pop_ok;
    push_ok  = push_req && !full_eff;
    ovf_evt  = push_req && full_eff;
  end

  assign head_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R1
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !ovf_evt && !pop_ok) |=> (count == $past(count) + CW'(1))); // R1
  AST_DROP_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (count == CW'(DEPTH))); // R3
  AST_EMPTY_POP_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && count == '0 && !push_req) |=> (count == '0)); // R4
endmodule

// File: rtl/cirb_flags.sv
module cirb_flags
  import cirb_pkg::*;
#(
  parameter int CW   = 5,
  parameter int LVLW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW-1:0]   count,
  input  logic            ovf_evt,
  input  logic            pkt_end,
  input  flags_t          clr,
  input  flags_t          en,
  input  logic [LVLW-1:0] level,
  output flags_t          flags,
  output logic            irq
);
  logic [CW:0] thr;
  logic        at_level;

  assign thr      = (CW+1)'(level) + (CW+1)'(1);
  assign at_level = ({1'b0, count} >= thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags.ovf   <= (flags.ovf & ~clr.ovf) | ovf_evt;
      flags.pend  <= (flags.pend & ~clr.pend) | pkt_end;
      flags.avail <= clr.avail ? 1'b0 : (flags.avail | at_level);
      irq         <= |(flags & en);
    end
  end

  AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flags.ovf); // R3
  AST_PEND_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |=> flags.pend); // R5
  AST_AVAIL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (at_level && !clr.avail) |=> flags.avail); // R6
  AST_AVAIL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr.avail |=> !flags.avail); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |=> !irq); // R9
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags.ovf && en.ovf) || (flags.pend && en.pend) || (flags.avail && en.avail)) |=> irq); // R9
endmodule

// File: rtl/cirb_regfile.sv
module cirb_regfile
  import cirb_pkg::*;
#(
  parameter int AW   = 8,
  parameter int RW   = 32,
  parameter int DW   = 8,
  parameter int CW   = 5,
  parameter int LVLW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [AW-1:0]   reg_addr,
  input  logic [RW-1:0]   reg_wdata,
  input  logic [CW-1:0]   count,
  input  flags_t          flags,
  input  logic [DW-1:0]   head_data,
  output logic            pop_req,
  output flags_t          clr,
  output flags_t          en,
  output logic [LVLW-1:0] level,
  output logic [RW-1:0]   reg_rdata
);
  logic [RW-1:0] hold_q [NHOLD];
  logic [RW-1:0] rd_val, stat_w, ien_w;
  logic          wr_stat, wr_ien;

  assign wr_stat = reg_wr && (reg_addr == AW'(OFS_STAT));
  assign wr_ien  = reg_wr && (reg_addr == AW'(OFS_IEN));
  assign pop_req = reg_rd && (reg_addr == AW'(OFS_DATA));

  always_comb begin
    clr.ovf   = wr_stat && reg_wdata[FLG_OVF];
    clr.pend  = wr_stat && reg_wdata[FLG_PEND];
    clr.avail = wr_stat && reg_wdata[FLG_AVAIL];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= '0;
      level <= '0;
      for (int i = 0; i < NHOLD; i++) hold_q[i] <= '0;
    end else begin
      if (wr_ien) begin
        en.ovf   <= reg_wdata[FLG_OVF];
        en.pend  <= reg_wdata[FLG_PEND];
        en.avail <= reg_wdata[FLG_AVAIL];
        level    <= reg_wdata[LVL_LSB +: LVLW];
      end
      for (int i = 0; i < NHOLD; i++)
        if (reg_wr && reg_addr == AW'(hold_offset(i))) hold_q[i] <= reg_wdata;
    end
  end

  always_comb begin
    stat_w = '0;
    stat_w[CNT_LSB +: CNT_W] = CNT_W'(count);
    stat_w[FLG_OVF]   = flags.ovf;
    stat_w[FLG_PEND]  = flags.pend;
    stat_w[FLG_AVAIL] = flags.avail;
    ien_w = '0;
    ien_w[FLG_OVF]   = en.ovf;
    ien_w[FLG_PEND]  = en.pend;
    ien_w[FLG_AVAIL] = en.avail;
    ien_w[LVL_LSB +: LVLW] = level;
  end

  always_comb begin
    rd_val = '0;
    if (reg_addr == AW'(OFS_DATA))      rd_val = (count != '0) ? RW'(head_data) : '0;
    else if (reg_addr == AW'(OFS_STAT)) rd_val = stat_w;
    else if (reg_addr == AW'(OFS_IEN))  rd_val = ien_w;
    for (int i = 0; i < NHOLD; i++)
      if (reg_addr == AW'(hold_offset(i))) rd_val = hold_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
  end

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && count == '0) |=> (reg_rdata == '0)); // R4
  AST_CLEAR_ONLY_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |-> (clr == '0)); // R7
endmodule

// File: rtl/cir_rx_buffer.sv
module cir_rx_buffer
  import cirb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int AW    = 8,
  parameter int RW    = 32,
  parameter int LVLW  = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  output logic          smp_ready,
  input  logic [DW-1:0] smp_data,
  input  logic          smp_pkt_end,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  output logic          irq
);
  logic [DW-1:0]   head_data;
  logic [CW-1:0]   count;
  logic            pop_req, pop_ok, ovf_evt;
  flags_t          flags, clr, en;
  logic [LVLW-1:0] level;

  assign smp_ready = 1'b1;

  cirb_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_req(smp_valid), .push_data(smp_data),
    .pop_req(pop_req), .head_data(head_data),
    .count(count), .pop_ok(pop_ok), .ovf_evt(ovf_evt)
  );

  cirb_flags #(.CW(CW), .LVLW(LVLW)) u_flags (
    .clk(clk), .rst_n(rst_n), .count(count), .ovf_evt(ovf_evt),
    .pkt_end(smp_pkt_end), .clr(clr), .en(en), .level(level),
    .flags(flags), .irq(irq)
  );

  cirb_regfile #(.AW(AW), .RW(RW), .DW(DW), .CW(CW), .LVLW(LVLW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .count(count),
    .flags(flags), .head_data(head_data), .pop_req(pop_req),
    .clr(clr), .en(en), .level(level), .reg_rdata(reg_rdata)
  );

  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready); // R11
  AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |-> (count != '0)); // R4
endmodule

// File: tb/test_cir_rx_buffer.sv
module test_cir_rx_buffer;
  localparam int DEPTH = 16;
  localparam logic [7:0] A_CTRL = 8'h00, A_RXC = 8'h10, A_DATA = 8'h20;
  localparam logic [7:0] A_IEN = 8'h2C, A_STAT = 8'h30, A_SMPL = 8'h34;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        smp_valid = 0, smp_pkt_end = 0, reg_wr = 0, reg_rd = 0;
  logic [7:0]  smp_data = 0, reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  wire         smp_ready, irq;
  wire  [31:0] reg_rdata;

  cir_rx_buffer i_cir_rx_buffer (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .smp_pkt_end(smp_pkt_end), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [7:0]  mq[$];
  bit          m_ovf = 0, m_pe = 0, m_da = 0;
  logic [31:0] m_ien = 0;
  logic [31:0] m_hold [3] = '{0, 0, 0};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a);
    logic [31:0] s;
    case (a)
      A_DATA: return (mq.size() > 0) ? {24'd0, mq[0]} : 32'd0;
      A_STAT: begin
        s = 32'd0;
        s[13:8] = 6'(mq.size());
        s[0] = m_ovf; s[1] = m_pe; s[4] = m_da;
        return s;
      end
      A_IEN:  return m_ien;
      A_CTRL: return m_hold[0];
      A_RXC:  return m_hold[1];
      A_SMPL: return m_hold[2];
      default: return 32'd0;
    endcase
  endfunction

  task automatic step(input bit v, input logic [7:0] d, input bit pe, input bit rd,
                      input bit wr, input logic [7:0] a, input logic [31:0] wd,
                      input string tag);
    logic [31:0] exp_rd;
    logic [7:0]  clr;
    bit pop, fulle, ovs, n_irq, n_ovf, n_pe, n_da;
    int sz, thr;
    smp_valid = v; smp_data = d; smp_pkt_end = pe;
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    sz     = mq.size();
    exp_rd = model_read(a);
    pop    = rd && (a == A_DATA) && (sz > 0);
    fulle  = (sz == DEPTH) && !pop;
    ovs    = v && fulle;
    clr    = (wr && a == A_STAT) ? wd[7:0] : 8'd0;
    thr    = int'(m_ien[11:8]) + 1;
    n_irq  = (m_ovf & m_ien[0]) | (m_pe & m_ien[1]) | (m_da & m_ien[4]);
    n_ovf  = (m_ovf & ~clr[0]) | ovs;
    n_pe   = (m_pe & ~clr[1]) | pe;
    n_da   = clr[4] ? 1'b0 : (m_da | (sz >= thr));
    @(posedge clk);
    @(negedge clk);
    m_ovf = n_ovf; m_pe = n_pe; m_da = n_da;
    if (pop) void'(mq.pop_front());
    if (v && !fulle) mq.push_back(d);
    if (wr && a == A_IEN) m_ien = wd & 32'h0000_0F13;
    if (wr && a == A_CTRL) m_hold[0] = wd;
    if (wr && a == A_RXC)  m_hold[1] = wd;
    if (wr && a == A_SMPL) m_hold[2] = wd;
    chk("R9 irq", {31'd0, irq}, {31'd0, n_irq});
    if (rd) chk(tag, reg_rdata, exp_rd);
    smp_valid = 0; smp_pkt_end = 0; reg_rd = 0; reg_wr = 0;
  endtask

  task automatic push(input logic [7:0] d);        step(1, d, 0, 0, 0, 8'h00, 0, "R1"); endtask
  task automatic rd(input logic [7:0] a, input string t); step(0, 0, 0, 1, 0, a, 0, t); endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] w); step(0, 0, 0, 0, 1, a, w, "R8"); endtask
  task automatic idle(); step(0, 0, 0, 0, 0, 8'h00, 0, "R9"); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4099));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 irq", {31'd0, irq}, 32'd0);
    chk("R11 ready", {31'd0, smp_ready}, 32'd1);
    rd(A_STAT, "R11 status");
    rd(A_IEN, "R11 ien");
    rd(A_CTRL, "R11 ctrl");

    // R10 holding registers and unmapped offsets
    wr(A_CTRL, 32'hA5A5_0033); wr(A_RXC, 32'h0000_0004); wr(A_SMPL, 32'h1234_5678);
    rd(A_CTRL, "R10 ctrl"); rd(A_RXC, "R10 rxcfg"); rd(A_SMPL, "R10 smpl");
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, "R10 unmapped"); rd(8'h04, "R10 unmapped");

    // R8 enable register readback with ignored bits
    wr(A_IEN, 32'hFFFF_FFFF); rd(A_IEN, "R8 ien mask");
    wr(A_IEN, 32'h0);

    // R1 / R2 ordering and live count
    for (int i = 0; i < 5; i++) push(8'h10 + 8'(i));
    rd(A_STAT, "R2 count5");
    for (int i = 0; i < 5; i++) rd(A_DATA, "R1 order");
    // R4 empty read
    rd(A_DATA, "R4 empty");
    rd(A_STAT, "R4 count0");

    // R6 level trigger at 8
    wr(A_STAT, 32'hFF);
    wr(A_IEN, 32'h0000_0710);
    for (int i = 0; i < 7; i++) push(8'h40 + 8'(i));
    idle(); rd(A_STAT, "R6 below");
    push(8'h47); idle(); idle();
    rd(A_STAT, "R6 at level");
    wr(A_STAT, 32'h10);
    rd(A_STAT, "R7 cleared");
    rd(A_STAT, "R6 reassert");

    // R3 overflow and order preserved
    for (int i = 0; i < 8; i++) push(8'h48 + 8'(i));
    for (int i = 0; i < 3; i++) push(8'hE0 + 8'(i));
    rd(A_STAT, "R3 ovf");
    step(1, 8'hEE, 0, 1, 0, A_DATA, 0, "R3 push+pop at full");
    rd(A_STAT, "R3 still full no new ovf");
    for (int i = 0; i < 16; i++) rd(A_DATA, "R3 order");
    rd(A_DATA, "R4 empty");

    // R5 / R7 packet end, clear vs set, zero bits
    wr(A_IEN, 32'h0000_0003);
    step(0, 0, 1, 0, 0, 8'h00, 0, "R5");
    idle(); rd(A_STAT, "R5 pend");
    wr(A_STAT, 32'h0000_0000); rd(A_STAT, "R7 zero write");
    step(0, 0, 1, 0, 1, A_STAT, 32'h02, "R7");
    rd(A_STAT, "R7 set wins");
    wr(A_STAT, 32'h03); idle(); rd(A_STAT, "R7 all clear");

    // randomized traffic
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      r = $urandom % 16;
      case (r)
        0, 1, 2, 3, 4: push(8'($urandom));
        5:  step(1, 8'($urandom), 1, 0, 0, 8'h00, 0, "R5");
        6, 7, 8: rd(A_DATA, "R1 random");
        9:  rd(A_STAT, "R2 random");
        10: wr(A_STAT, 32'($urandom % 256));
        11: wr(A_IEN, $urandom);
        12: rd(A_IEN, "R8 random");
        13: step(1, 8'($urandom), 0, 1, 0, A_DATA, 0, "R3 random");
        default: idle();
      endcase
    end
    while (mq.size() > 0) rd(A_DATA, "R1 drain");
    rd(A_STAT, "R2 final");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule